// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Counters

This block predicts the next fetch address for a front end that brings in four sequential instructions per cycle. Each fetch group is an aligned 16-byte window. The block holds a small direct-mapped table, and every slot of the table records the following:

- a valid flag;
- the upper address bits of the branch that owns the slot;
- the branch's last taken target;
- a two-bit saturating direction counter.

A lookup is purely combinational. In the same cycle that the fetch address is presented, the block returns a hit flag, a taken flag and the predicted next fetch address. Instructions start at byte address 0, and the sequential successor of an address is that address plus 4.

The branch unit reports each resolved branch on the update port. It gives the branch's byte address, whether the branch was taken, and its real target. The update is written at the next rising clock edge.

- If the branch already owns its slot, the counter moves one step toward the outcome.
- If the branch does not own its slot, the slot is claimed for it. The counter starts at weakly taken, and the outcome of that first report is not applied to the counter.

The table depth and the lowest address bit of the index field are parameters. The slot is chosen by address bits 7 down to 4, so all four instructions of a fetch group share one slot.

Top module: `btb_dir_predictor`

## Requirements
- R1: After reset every slot is invalid. Any lookup then returns pred_hit=0 and pred_taken=0, and pred_next_pc is the fetch address plus 4; a lookup of address 0 gives 4.
- R2: The slot is selected by address bits [7:4]. The stored tag is bits [31:8]. A lookup hits only when the selected slot is valid and its tag equals bits [31:8] of the fetch address. Two addresses that differ only in bits [3:0] therefore hit together, and two addresses with the same bits [7:4] but different bits [31:8] cannot both hit.
- R3: An update (br_valid=1) whose address misses claims the slot. The slot takes the new tag and target, and its counter is set to weakly taken (2'b10) whatever the reported outcome. From the next cycle, a lookup of that address hits, predicts taken and returns the reported target.
- R4: The counter values are 2'b00 strongly not taken, 2'b01 weakly not taken, 2'b10 weakly taken and 2'b11 strongly taken. An update that hits moves the counter up by one on a taken outcome, saturating at 2'b11. It moves the counter down by one on a not-taken outcome, saturating at 2'b00.
- R5: pred_taken is 1 exactly when the lookup hits and the slot's counter is 2'b10 or 2'b11.
- R6: pred_next_pc equals the stored target when pred_taken=1. Otherwise it equals the fetch address plus 4.
- R7: When a lookup and an update select the same slot in one cycle, the lookup returns the slot's contents from before the update.
- R8: An update that hits with a taken outcome replaces the stored target with br_target. An update that hits with a not-taken outcome leaves the stored target unchanged.
- R9: While br_valid=0, the update inputs change no slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Byte address of the current fetch group |
| pred_hit | output | 1 | Selected slot is valid and its tag matches |
| pred_taken | output | 1 | Hit and counter in a taken state |
| pred_next_pc | output | 32 | Predicted next fetch address |
| br_valid | input | 1 | A resolved branch is reported this cycle |
| br_pc | input | 32 | Byte address of the resolved branch |
| br_taken | input | 1 | Actual direction of the resolved branch |
| br_target | input | 32 | Actual target of the resolved branch |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 16 slots, and the index starting at bit 4. With these values the tag is exactly bits [31:8]. Random addresses are drawn from four tag values and all sixteen indices. This keeps collisions frequent, so slot claiming, aliasing between tags and counter saturation in both directions all occur often. Directed sequences walk one counter through all four states and past both ends, and present a lookup and an update of the same slot in the same cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // One saturating step of the direction counter toward the outcome.
  function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
    ctr_e nxt;
    unique case (cur)
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      default: nxt = taken ? CTR_ST  : CTR_WT;
    endcase
    return nxt;
  endfunction

  function automatic logic ctr_is_taken(input ctr_e cur);
    return (cur == CTR_WT) || (cur == CTR_ST);
  endfunction

endpackage

// File: rtl/bp_addr_split.sv
module bp_addr_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_LO = 4,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0]              addr,
  output logic [IDX_W-1:0]               idx,
  output logic [ADDR_W-IDX_LO-IDX_W-1:0] tag
);
  localparam int TAG_LO = IDX_LO + IDX_W;

  always_comb begin
    idx = addr[TAG_LO-1:IDX_LO];
    tag = addr[ADDR_W-1:TAG_LO];
  end
endmodule

// File: rtl/bp_entry.sv
module bp_entry
  import bp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              upd_taken,
  input  logic [TAG_W-1:0]  upd_tag,
  input  logic [ADDR_W-1:0] upd_target,
  output logic              ent_valid,
  output logic [TAG_W-1:0]  ent_tag,
  output logic [ADDR_W-1:0] ent_target,
  output ctr_e              ent_ctr
);
  logic              own_hit;
  logic              valid_d;
  logic [TAG_W-1:0]  tag_d;
  logic [ADDR_W-1:0] target_d;
  ctr_e              ctr_d;

  always_comb begin
    own_hit  = ent_valid && (ent_tag == upd_tag);
    valid_d  = ent_valid;
    tag_d    = ent_tag;
    target_d = ent_target;
    ctr_d    = ent_ctr;
    if (own_hit) begin
      ctr_d = ctr_step(ent_ctr, upd_taken);
      if (upd_taken) target_d = upd_target;
    end else begin
      valid_d  = 1'b1;
      tag_d    = upd_tag;
      target_d = upd_target;
      ctr_d    = CTR_WT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid  <= 1'b0;
      ent_tag    <= '0;
      ent_target <= '0;
      ent_ctr    <= CTR_WT;
    end else if (sel) begin
      ent_valid  <= valid_d;
      ent_tag    <= tag_d;
      ent_target <= target_d;
      ent_ctr    <= ctr_d;
    end
  end
endmodule

// File: rtl/bp_lookup.sv
module bp_lookup
  import bp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int TAG_W       = 24,
  parameter int INSTR_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [TAG_W-1:0]  pc_tag,
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [ADDR_W-1:0] ent_target,
  input  ctr_e              ent_ctr,
  output logic              hit,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc
);
  logic [ADDR_W-1:0] seq_pc;

  always_comb begin
    seq_pc  = pc + ADDR_W'(INSTR_BYTES);
    hit     = ent_valid && (ent_tag == pc_tag);
    taken   = hit && ctr_is_taken(ent_ctr);
    next_pc = taken ? ent_target : seq_pc;
  end
endmodule

// File: rtl/btb_dir_predictor.sv
module btb_dir_predictor
  import bp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  parameter int IDX_LO  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next_pc,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target
);
  localparam int IDX_W       = $clog2(ENTRIES);
  localparam int TAG_W       = ADDR_W - IDX_LO - IDX_W;
  localparam int INSTR_BYTES = 4;

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;

  logic              slot_valid  [ENTRIES];
  logic [TAG_W-1:0]  slot_tag    [ENTRIES];
  logic [ADDR_W-1:0] slot_target [ENTRIES];
  ctr_e              slot_ctr    [ENTRIES];

  bp_addr_split #(.ADDR_W(ADDR_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W)) u_split_lk (
    .addr(fetch_pc), .idx(lk_idx), .tag(lk_tag)
  );

  bp_addr_split #(.ADDR_W(ADDR_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W)) u_split_up (
    .addr(br_pc), .idx(up_idx), .tag(up_tag)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic wr_en;
    always_comb wr_en = br_valid && (up_idx == IDX_W'(g));

    bp_entry #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (wr_en),
      .upd_taken  (br_taken),
      .upd_tag    (up_tag),
      .upd_target (br_target),
      .ent_valid  (slot_valid[g]),
      .ent_tag    (slot_tag[g]),
      .ent_target (slot_target[g]),
      .ent_ctr    (slot_ctr[g])
    );
  end

  bp_lookup #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .INSTR_BYTES(INSTR_BYTES)) u_lookup (
    .pc         (fetch_pc),
    .pc_tag     (lk_tag),
    .ent_valid  (slot_valid[lk_idx]),
    .ent_tag    (slot_tag[lk_idx]),
    .ent_target (slot_target[lk_idx]),
    .ent_ctr    (slot_ctr[lk_idx]),
    .hit        (pred_hit),
    .taken      (pred_taken),
    .next_pc    (pred_next_pc)
  );
endmodule

// File: rtl/btb_dir_predictor_chk.sv
module btb_dir_predictor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              pred_hit,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] pred_next_pc,
  input logic              br_valid,
  input logic [ADDR_W-1:0] br_pc,
  input logic              br_taken
);
  // R5
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> pred_hit);

  // R6
  seq_when_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_taken |-> (pred_next_pc == fetch_pc + ADDR_W'(4)));

  // R3
  alloc_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> (fetch_pc != $past(br_pc)) || pred_hit);

  // R4
  taken_stays_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_taken && fetch_pc == br_pc && pred_taken)
      |=> (fetch_pc != $past(fetch_pc)) || pred_taken);

  // R4
  not_taken_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_taken && fetch_pc == br_pc && pred_hit && !pred_taken)
      |=> (fetch_pc != $past(fetch_pc)) || (pred_hit && !pred_taken));

  // R9
  idle_keeps_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && $stable(fetch_pc)) |=> $stable(pred_hit) || (fetch_pc != $past(fetch_pc)));
endmodule

bind btb_dir_predictor btb_dir_predictor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_pc     (fetch_pc),
  .pred_hit     (pred_hit),
  .pred_taken   (pred_taken),
  .pred_next_pc (pred_next_pc),
  .br_valid     (br_valid),
  .br_pc        (br_pc),
  .br_taken     (br_taken)
);

// File: tb/tb_btb_dir_predictor.sv
`timescale 1ns/1ps
module tb_btb_dir_predictor;
  logic        clk;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        pred_hit, pred_taken;
  logic [31:0] pred_next_pc;
  logic        br_valid;
  logic [31:0] br_pc;
  logic        br_taken;
  logic [31:0] br_target;

  int n_tests = 0;
  int n_fail  = 0;

  logic        m_valid [16];
  logic [23:0] m_tag   [16];
  logic [31:0] m_tgt   [16];
  logic [1:0]  m_ctr   [16];

  btb_dir_predictor dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .br_valid(br_valid), .br_pc(br_pc), .br_taken(br_taken), .br_target(br_target)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [33:0] expect_pred(input logic [31:0] pc);
    logic [3:0] ix;
    logic h, t;
    ix = pc[7:4];
    h  = m_valid[ix] && (m_tag[ix] == pc[31:8]);
    t  = h && m_ctr[ix][1];
    return {h, t, (t ? m_tgt[ix] : pc + 32'd4)};
  endfunction

  task automatic model_update(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
    logic [3:0] ix;
    ix = pc[7:4];
    if (m_valid[ix] && m_tag[ix] == pc[31:8]) begin
      if (tk) begin
        if (m_ctr[ix] != 2'b11) m_ctr[ix] = m_ctr[ix] + 2'd1;
        m_tgt[ix] = tg;
      end else if (m_ctr[ix] != 2'b00) begin
        m_ctr[ix] = m_ctr[ix] - 2'd1;
      end
    end else begin
      m_valid[ix] = 1'b1;
      m_tag[ix]   = pc[31:8];
      m_tgt[ix]   = tg;
      m_ctr[ix]   = 2'b10;
    end
  endtask

  task automatic check_pred(input string req);
    logic [33:0] exp_v, act_v;
    exp_v = expect_pred(fetch_pc);
    act_v = {pred_hit, pred_taken, pred_next_pc};
    n_tests++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s pc=%h actual hit/taken/next=%b/%b/%h expected %b/%b/%h",
               req, fetch_pc, act_v[33], act_v[32], act_v[31:0],
               exp_v[33], exp_v[32], exp_v[31:0]);
    end
  endtask

  // One cycle: drive on the falling edge, check before the rising edge, then
  // commit the update into the model.
  task automatic cyc(input logic [31:0] lk, input logic uv, input logic [31:0] upc,
                     input logic ut, input logic [31:0] utg, input string req);
    @(negedge clk);
    fetch_pc  = lk;
    br_valid  = uv;
    br_pc     = upc;
    br_taken  = ut;
    br_target = utg;
    #2;
    check_pred(req);
    @(posedge clk);
    #1;
    if (uv) model_update(upc, ut, utg);
  endtask

  task automatic look(input logic [31:0] lk, input string req);
    cyc(lk, 1'b0, 32'h0, 1'b0, 32'h0, req);
  endtask

  task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tg, input string req);
    cyc(pc, 1'b1, pc, tk, tg, req);
  endtask

  function automatic logic [31:0] rand_pc();
    logic [31:0] r;
    r = $urandom;
    return {22'd0, r[9:8], r[7:4], r[3:2], 2'b00};
  endfunction

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    void'($urandom(32'd2410));
    for (int i = 0; i < 16; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 2'b10;
    end
    rst_n = 1'b0; fetch_pc = '0; br_valid = 1'b0; br_pc = '0;
    br_taken = 1'b0; br_target = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty table, first address gives 4
    look(32'h0, "R1");
    look(32'h0000_1234 & 32'hFFFF_FFFC, "R1");

    // R3: claim on a not-taken report still starts weakly taken
    a = 32'h0000_1230;
    upd(a, 1'b0, 32'h0000_0400, "R3");
    look(a, "R3");
    // R2: other word in the same group hits; alias with other tag misses
    look(a + 32'h8, "R2");
    b = a + 32'h100;
    look(b, "R2");
    // R4: walk up past saturation
    upd(a, 1'b1, 32'h0000_0400, "R4");
    upd(a, 1'b1, 32'h0000_0400, "R4");
    look(a, "R4");
    // R7: lookup and update of the same slot; pre-update value seen
    upd(a, 1'b0, 32'h0000_0400, "R7");
    look(a, "R5");
    upd(a, 1'b0, 32'h0000_0400, "R5");
    look(a, "R5");
    upd(a, 1'b0, 32'h0000_0400, "R4");
    upd(a, 1'b0, 32'h0000_0400, "R4");
    upd(a, 1'b1, 32'h0000_0400, "R4");
    look(a, "R4");
    upd(a, 1'b1, 32'h0000_0800, "R8");
    look(a, "R8");
    upd(a, 1'b0, 32'h0000_0C00, "R8");
    upd(a, 1'b1, 32'h0000_0800, "R8");
    look(a, "R6");
    // R9: inactive update inputs leave the slot alone
    cyc(a, 1'b0, a, 1'b0, 32'hDEAD_BEE0, "R9");
    cyc(a, 1'b0, b, 1'b1, 32'hDEAD_BEE0, "R9");
    look(a, "R9");
    look(b, "R9");
    // R2: alias claims slot, evicting the first owner
    upd(b, 1'b1, 32'h0000_0100, "R2");
    look(a, "R2");
    look(b, "R2");

    // Random mix of lookups and updates over a small address pool
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      logic [31:0] p, q;
      r = $urandom;
      p = rand_pc();
      q = r[0] ? p : rand_pc();
      cyc(p, r[1] | r[2], q, r[3], {16'd0, r[15:6], 6'd0} & 32'hFFFF_FFFC,
          r[1] ? "R6" : "R4");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule